// File: doc/BRIEF.md
# Mailbox Receive Acceptance Filter

This block sits behind a bus protocol engine and decides where a freshly received frame is kept. It has a bank of mailboxes. Each mailbox holds a few settings: an enable bit, a direction bit that marks it as a receiver, an interrupt enable, a stored identifier with a format flag (standard 11-bit or extended 29-bit), and an acceptance mask. When the engine presents a frame, every mailbox compares its settings with the frame at the same time. The lowest-numbered mailbox that accepts the frame stores the identifier, the length code and the 64-bit data word, and it sets its sticky pending flag. If no mailbox accepts the frame, the frame is dropped and nothing changes.

After reset the block runs in a reduced mode in which only the lower half of the mailboxes can receive. A mode bit opens all of them. Software writes the settings through a small word-wide register port. It clears pending flags by writing ones, and it reads back the stored contents of one mailbox at a time through a read port.

Top module: `mbox_rx_filter`

## Requirements
- R1: After reset all mailboxes are disabled, not receivers, and hold zero identifier, mask, format, length and data. The pending vector, `irq`, `rx_hit` and `rx_drop` are zero, and the reduced mode is active.
- R2: A mailbox can accept a frame only if its enable bit (control field 0, bit 0) and its receive-direction bit (bit 1) are both set.
- R3: Identifier bit k takes part in the comparison only where mask bit k is 1. Where the mask bit is 0, that bit is ignored.
- R4: The format flag (identifier field 1, bit 31) must equal `rx_ext`. For a standard frame only identifier bits 10:0 are compared. For an extended frame bits 28:0 are compared.
- R5: When several mailboxes accept a frame, only the lowest-numbered one is written and has its pending bit set.
- R6: A frame that no mailbox accepts gives a one-cycle `rx_drop` pulse. It changes no mailbox contents and no pending bit.
- R7: In reduced mode, mailboxes 16 to 31 never accept a frame. Writing field 3 with bit 0 = 1 selects the full mode, where all 32 mailboxes take part. A mode write in the same cycle as a frame takes effect for the next frame.
- R8: On the clock edge that samples `rx_valid`, the winning mailbox stores `rx_id`, `rx_len` and `rx_data`. In the cycle after that edge, `rx_hit` is 1 for one cycle, `hit_idx` gives the winner, and the read port shows the stored values.
- R9: A pending bit stays set until software writes 1 to its position in `pend_clr`. A clear and a store that hit the same mailbox in the same cycle leave the bit set.
- R10: `irq` is 1 exactly when some mailbox has both its pending bit and its interrupt-enable bit (control field 0, bit 2) set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_mbox | input | 5 | Mailbox addressed by the write |
| cfg_field | input | 2 | 0 control, 1 identifier/format, 2 mask, 3 mode |
| cfg_wdata | input | 32 | Write data |
| pend_clr | input | 32 | Write-one-to-clear for pending bits |
| rx_valid | input | 1 | One-cycle frame strobe |
| rx_id | input | 29 | Frame identifier (standard in bits 10:0) |
| rx_ext | input | 1 | Frame uses extended identifier |
| rx_len | input | 4 | Frame length code |
| rx_data | input | 64 | Frame data |
| rd_mbox | input | 5 | Mailbox shown on the read port |
| rd_id | output | 29 | Stored identifier |
| rd_ext | output | 1 | Stored format flag |
| rd_len | output | 4 | Stored length code |
| rd_data | output | 64 | Stored data |
| pending | output | 32 | Sticky per-mailbox receive flags |
| irq | output | 1 | Receive interrupt |
| rx_hit | output | 1 | Frame was stored (one cycle) |
| hit_idx | output | 5 | Mailbox that stored the frame |
| rx_drop | output | 1 | Frame was discarded (one cycle) |

## Verification
The bench makes several mailboxes accept the same frame. A priority encoder that runs the wrong way would write the higher mailbox and set the wrong pending bit. It sends frames that differ only in masked-out bits, only in identifier bits above bit 10 of a standard frame, or only in the format flag. A comparator that ignored the mask or the format would then store frames that should be dropped, or drop frames that should be stored. A mailbox above 15 that matches is tried in both modes, including a mode change in the same cycle as a frame, which shows whether the mode gate acts late or not at all. A pending clear that lands in the same cycle as a new store checks that the set wins.

// File: rtl/mbox_rx_filter.sv
module mbox_rx_filter #(
  parameter int NMB     = 32,
  parameter int NMB_RED = 16,
  parameter int IDW     = 29,
  parameter int STDW    = 11,
  parameter int DW      = 64,
  parameter int LW      = 4,
  localparam int MBW    = $clog2(NMB)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [MBW-1:0] cfg_mbox,
  input  logic [1:0]     cfg_field,
  input  logic [31:0]    cfg_wdata,
  input  logic [NMB-1:0] pend_clr,
  input  logic           rx_valid,
  input  logic [IDW-1:0] rx_id,
  input  logic           rx_ext,
  input  logic [LW-1:0]  rx_len,
  input  logic [DW-1:0]  rx_data,
  input  logic [MBW-1:0] rd_mbox,
  output logic [IDW-1:0] rd_id,
  output logic           rd_ext,
  output logic [LW-1:0]  rd_len,
  output logic [DW-1:0]  rd_data,
  output logic [NMB-1:0] pending,
  output logic           irq,
  output logic           rx_hit,
  output logic [MBW-1:0] hit_idx,
  output logic           rx_drop
);

  logic [NMB-1:0] en_q, dir_q, ie_q, ext_q, pend_q, match;
  logic [IDW-1:0] id_q   [NMB];
  logic [IDW-1:0] mask_q [NMB];
  logic [LW-1:0]  len_q  [NMB];
  logic [DW-1:0]  data_q [NMB];
  logic           full_q, found, store;
  logic [MBW-1:0] win;

  wire [IDW-1:0] cmp_bits = rx_ext ? {IDW{1'b1}} : {{(IDW-STDW){1'b0}}, {STDW{1'b1}}};

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = NMB - 1; i >= 0; i--) begin
      if (match[i]) begin
        found = 1'b1;
        win   = MBW'(i);
      end
    end
  end

  assign store = rx_valid & found;

  for (genvar i = 0; i < NMB; i++) begin : g_mb
    logic           en_r, dir_r, ie_r, ext_r, pend_r;
    logic [IDW-1:0] id_r, mask_r;
    logic [LW-1:0]  len_r;
    logic [DW-1:0]  data_r;
    wire            sel_cfg = cfg_we && (cfg_mbox == MBW'(i));
    wire            sel_st  = store && (win == MBW'(i));

    assign match[i] = en_r & dir_r & (ext_r == rx_ext)
                    & (((id_r ^ rx_id) & mask_r & cmp_bits) == '0)
                    & ((i < NMB_RED) | full_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r <= 1'b0; dir_r <= 1'b0; ie_r <= 1'b0; ext_r <= 1'b0; pend_r <= 1'b0;
        id_r <= '0; mask_r <= '0; len_r <= '0; data_r <= '0;
      end else begin
        if (sel_cfg) begin
          case (cfg_field)
            2'd0: {ie_r, dir_r, en_r} <= cfg_wdata[2:0];
            2'd1: begin id_r <= cfg_wdata[IDW-1:0]; ext_r <= cfg_wdata[31]; end
            2'd2: mask_r <= cfg_wdata[IDW-1:0];
            default: ;
          endcase
        end
        if (sel_st) begin
          id_r   <= rx_id;
          len_r  <= rx_len;
          data_r <= rx_data;
        end
        pend_r <= (pend_r & ~pend_clr[i]) | sel_st;
      end
    end

    assign en_q[i]   = en_r;
    assign dir_q[i]  = dir_r;
    assign ie_q[i]   = ie_r;
    assign ext_q[i]  = ext_r;
    assign pend_q[i] = pend_r;
    assign id_q[i]   = id_r;
    assign mask_q[i] = mask_r;
    assign len_q[i]  = len_r;
    assign data_q[i] = data_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      rx_hit  <= 1'b0;
      rx_drop <= 1'b0;
      hit_idx <= '0;
    end else begin
      if (cfg_we && cfg_field == 2'd3) full_q <= cfg_wdata[0];
      rx_hit  <= store;
      rx_drop <= rx_valid & ~found;
      if (store) hit_idx <= win;
    end
  end

  assign pending = pend_q;
  assign irq     = |(pend_q & ie_q);
  assign rd_id   = id_q[rd_mbox];
  assign rd_ext  = ext_q[rd_mbox];
  assign rd_len  = len_q[rd_mbox];
  assign rd_data = data_q[rd_mbox];

  logic unused_ok;
  assign unused_ok = &{1'b0, en_q, dir_q, mask_q[0]};

endmodule

// File: rtl/mbox_rx_filter_chk.sv
module mbox_rx_filter_chk #(
  parameter int NMB     = 32,
  parameter int NMB_RED = 16,
  localparam int MBW    = $clog2(NMB)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_valid,
  input logic           rx_hit,
  input logic           rx_drop,
  input logic [MBW-1:0] hit_idx,
  input logic [NMB-1:0] pending,
  input logic           full_q
);

  assert_hit_or_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_hit && rx_drop));

  assert_frame_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (rx_hit || rx_drop));

  assert_outcome_needs_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit || rx_drop) |-> $past(rx_valid));

  assert_hit_sets_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |-> pending[hit_idx]);

  assert_drop_keeps_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> ((pending & ~$past(pending)) == '0));

  assert_idle_keeps_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_valid) |-> ((pending & ~$past(pending)) == '0));

  assert_reduced_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && !$past(full_q)) |-> (hit_idx < MBW'(NMB_RED)));

  assert_single_new_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pending & ~$past(pending)) <= 1);

endmodule

bind mbox_rx_filter mbox_rx_filter_chk #(.NMB(NMB), .NMB_RED(NMB_RED)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_hit(rx_hit),
  .rx_drop(rx_drop), .hit_idx(hit_idx), .pending(pending), .full_q(full_q)
);

// File: tb/mbox_rx_filter_tb.sv
`timescale 1ns/1ps
module mbox_rx_filter_tb;
  localparam int NMB = 32, IDW = 29, DW = 64, LW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_mbox = '0;
  logic [1:0] cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NMB-1:0] pend_clr = '0;
  logic rx_valid = 1'b0;
  logic [IDW-1:0] rx_id = '0;
  logic rx_ext = 1'b0;
  logic [LW-1:0] rx_len = '0;
  logic [DW-1:0] rx_data = '0;
  logic [4:0] rd_mbox = '0;
  logic [IDW-1:0] rd_id;
  logic rd_ext;
  logic [LW-1:0] rd_len;
  logic [DW-1:0] rd_data;
  logic [NMB-1:0] pending;
  logic irq, rx_hit, rx_drop;
  logic [4:0] hit_idx;

  mbox_rx_filter u_dut (.*);

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  bit m_en[NMB], m_dir[NMB], m_ie[NMB], m_ext[NMB];
  bit [IDW-1:0] m_id[NMB], m_mask[NMB];
  bit [LW-1:0] m_len[NMB];
  bit [DW-1:0] m_data[NMB];
  bit [NMB-1:0] m_pend;
  bit m_full, m_hit, m_drop;
  int m_idx;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit accepts(int i);
    bit [IDW-1:0] cm;
    if (!(m_en[i] && m_dir[i])) return 0;
    if (!m_full && i >= 16) return 0;
    if (m_ext[i] != rx_ext) return 0;
    cm = rx_ext ? {IDW{1'b1}} : IDW'(11'h7FF);
    return ((m_id[i] ^ rx_id) & m_mask[i] & cm) == 0;
  endfunction

  task automatic model_step();
    int w = -1;
    if (rx_valid)
      for (int i = 0; i < NMB; i++) if (w < 0 && accepts(i)) w = i;
    if (cfg_we) begin
      case (cfg_field)
        2'd0: begin m_en[cfg_mbox] = cfg_wdata[0]; m_dir[cfg_mbox] = cfg_wdata[1]; m_ie[cfg_mbox] = cfg_wdata[2]; end
        2'd1: begin m_id[cfg_mbox] = cfg_wdata[IDW-1:0]; m_ext[cfg_mbox] = cfg_wdata[31]; end
        2'd2: m_mask[cfg_mbox] = cfg_wdata[IDW-1:0];
        default: m_full = cfg_wdata[0];
      endcase
    end
    m_pend = m_pend & ~pend_clr;
    if (rx_valid && w >= 0) begin
      m_id[w] = rx_id; m_len[w] = rx_len; m_data[w] = rx_data; m_pend[w] = 1'b1;
      m_idx = w;
    end
    m_hit  = rx_valid && (w >= 0);
    m_drop = rx_valid && (w < 0);
  endtask

  task automatic compare();
    bit any = 0;
    for (int i = 0; i < NMB; i++) if (m_pend[i] && m_ie[i]) any = 1;
    chk("pending", pending, m_pend);
    chk("irq R10", irq, any);
    chk("rx_hit", rx_hit, m_hit);
    chk("rx_drop", rx_drop, m_drop);
    if (m_hit) chk("hit_idx", hit_idx, m_idx);
    chk("rd_id", rd_id, m_id[rd_mbox]);
    chk("rd_ext", rd_ext, m_ext[rd_mbox]);
    chk("rd_len", rd_len, m_len[rd_mbox]);
    chk("rd_data", rd_data, m_data[rd_mbox]);
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare();
    cfg_we = 1'b0; rx_valid = 1'b0; pend_clr = '0;
  endtask

  task automatic cfg(int mb, int field, logic [31:0] d);
    cfg_we = 1'b1; cfg_mbox = 5'(mb); cfg_field = 2'(field); cfg_wdata = d;
    tick();
  endtask

  task automatic setup(int mb, bit ie, bit ext, logic [IDW-1:0] id, logic [IDW-1:0] mask);
    cfg(mb, 1, {ext, 2'b00, id});
    cfg(mb, 2, {3'b000, mask});
    cfg(mb, 0, {29'd0, ie, 2'b11});
  endtask

  task automatic put_frame(logic [IDW-1:0] id, bit ext, logic [LW-1:0] len, logic [DW-1:0] d);
    rx_valid = 1'b1; rx_id = id; rx_ext = ext; rx_len = len; rx_data = d;
  endtask

  task automatic frame(logic [IDW-1:0] id, bit ext, logic [LW-1:0] len, logic [DW-1:0] d);
    put_frame(id, ext, len, d);
    tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    rd_mbox = 5'd9;
    compare();
    chk("reset pending R1", pending, '0);
    chk("reset irq R1", irq, 0);
    rst_n = 1'b1;
    tick();

    tag = "R6";
    frame(29'h123, 0, 4'd3, 64'h1111);
    chk("drop with no mailbox R6", rx_drop, 1);

    tag = "R8";
    setup(3, 1, 0, 29'h123, 29'h7FF);
    rd_mbox = 5'd3;
    frame(29'h123, 0, 4'd8, 64'hDEAD_BEEF_0123_4567);
    chk("hit mailbox 3 R8", hit_idx, 3);
    chk("stored data R8", rd_data, 64'hDEAD_BEEF_0123_4567);
    chk("stored len R8", rd_len, 8);
    chk("irq after store R10", irq, 1);

    tag = "R9";
    pend_clr = 32'h8;
    tick();
    chk("pending cleared R9", pending[3], 0);
    put_frame(29'h123, 0, 4'd1, 64'h55);
    pend_clr = 32'h8;
    tick();
    chk("set wins over clear R9", pending[3], 1);
    pend_clr = 32'h8; tick();

    tag = "R2";
    setup(1, 0, 0, 29'h123, 29'h7FF);
    cfg(1, 0, 32'h1);
    setup(2, 0, 0, 29'h123, 29'h7FF);
    cfg(2, 0, 32'h2);
    frame(29'h123, 0, 4'd2, 64'h22);
    chk("disabled or transmit skipped R2", hit_idx, 3);
    chk("mailbox 1 not pending R2", pending[2:1], 0);
    pend_clr = '1; tick();

    tag = "R3";
    setup(5, 0, 0, 29'h100, 29'h700);
    frame(29'h1AB, 0, 4'd4, 64'h33);
    chk("masked bits ignored R3", hit_idx, 5);
    frame(29'h2AB, 0, 4'd4, 64'h34);
    chk("compared bit mismatch R3", rx_drop, 1);

    tag = "R4";
    frame(29'h123, 1, 4'd5, 64'h44);
    chk("format mismatch R4", rx_drop, 1);
    frame(29'h1FFF_F923, 0, 4'd5, 64'h45);
    chk("std upper bits ignored R4", hit_idx, 3);
    setup(7, 0, 1, 29'h1ABC_DEF0, 29'h1FFF_FFFF);
    frame(29'h1ABC_DEF0, 1, 4'd6, 64'h46);
    chk("extended hit R4", hit_idx, 7);
    frame(29'h0ABC_DEF0, 1, 4'd6, 64'h47);
    chk("extended upper bit compared R4", rx_drop, 1);
    pend_clr = '1; tick();

    tag = "R5";
    setup(6, 0, 0, 29'h000, 29'h000);
    frame(29'h123, 0, 4'd7, 64'h66);
    chk("lowest wins R5", hit_idx, 3);
    chk("only one pending R5", pending, 32'h8);
    frame(29'h777, 0, 4'd7, 64'h67);
    chk("catch-all mailbox R5", hit_idx, 6);
    pend_clr = '1; tick();

    tag = "R7";
    setup(20, 1, 0, 29'h555, 29'h7FF);
    frame(29'h555, 0, 4'd1, 64'h77);
    chk("upper mailbox off in reduced R7", hit_idx, 6);
    cfg(6, 0, 32'h0);
    put_frame(29'h555, 0, 4'd1, 64'h78);
    cfg_we = 1; cfg_field = 2'd3; cfg_wdata = 32'h1;
    tick();
    chk("mode write applies later R7", rx_drop, 1);
    rd_mbox = 5'd20;
    frame(29'h555, 0, 4'd2, 64'h79);
    chk("full mode hit R7", hit_idx, 20);
    chk("upper store R8", rd_data, 64'h79);
    cfg(0, 3, 32'h0);
    frame(29'h555, 0, 4'd2, 64'h7A);
    chk("back to reduced R7", rx_drop, 1);

    tag = "R10";
    pend_clr = '1; tick();
    frame(29'h100, 0, 4'd1, 64'h88);
    chk("pending without irq enable R10", irq, 0);
    chk("pending 5 R10", pending[5], 1);

    tag = "R9";
    for (int k = 0; k < 40; k++) begin
      rd_mbox = 5'(k);
      if (k % 3 == 0) put_frame(29'(k * 37), k[0], 4'(k), 64'(k) * 64'h0101_0101);
      if (k % 5 == 0) pend_clr = 32'(1) << (k % 8);
      tick();
    end
    finish_run();
  end
endmodule